// File: doc/BRIEF.md
# First-Fault Gather Load Tracker

This block sequences a predicated gather load that must never trap. A start pulse captures a per-lane activity mask and a vector of per-lane addresses. The block then walks the lanes from lane 0 upward. For each active lane it places one request on a simple memory port and waits for the response before it moves on. Returned data is written into the matching element of the destination vector. Inactive lanes cost one cycle, send nothing to memory and stay zero.

A response that carries the fault flag raises no error. The block clears the first-fault predicate from the faulting lane up to the top lane and ends the load there. Software-visible state is the destination vector, the first-fault predicate and a flag holding its lowest bit. The predicate has one bit per data byte. It becomes all ones only through a set command, and a load can only clear bits.

Top module: `ffl_gather_tracker`

## Requirements
- R1: After reset the first-fault predicate is all ones, the destination vector is zero, and `mem_req`, `done` and `busy` are low.
- R2: A one-cycle `ffr_set` sets every bit of the first-fault predicate to 1 on the next clock edge. The predicate is LANES*ELEM_W/8 bits wide, and bit j belongs to lane j/(ELEM_W/8).
- R3: Active lanes are requested strictly in ascending lane order. Only one request is outstanding at a time. `mem_req` stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is seen.
- R4: A lane whose response has no fault gets the returned data in its destination element, and its predicate bits keep their value.
- R5: A lane whose bit in `act_mask` is 0 issues no request, cannot fault even if its address would fault, leaves its predicate bits unchanged, and reads zero in the destination.
- R6: A faulting response clears the predicate bits of that lane and of every higher lane. No further request follows, and the destination elements of that lane and all higher lanes read zero. No port signals an error.
- R7: `done` is high for exactly one cycle per load. It rises on the edge after the last lane is handled or after the faulting response, and `busy` is low while `done` is high.
- R8: `ffr_first` equals bit 0 of the first-fault predicate. It is low after a fault in lane 0.
- R9: When `ffr_set` falls in the same cycle as a fault clear, the clear wins for the faulting lane and the lanes above it. All bits below that lane become 1.
- R10: A `start` pulse while `busy` is high is ignored: the running load keeps its captured mask and addresses, and no extra requests follow.
- R11: A load never changes a predicate bit from 0 to 1. Only `ffr_set` does that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load; mask and addresses are captured in the same cycle |
| act_mask | input | LANES | Lane activity mask, bit l for lane l |
| addr_vec | input | LANES*ADDR_W | Per-lane addresses, lane l at bits [l*ADDR_W +: ADDR_W] |
| ffr_set | input | 1 | Set every first-fault predicate bit to 1 |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_addr | output | ADDR_W | Address of the current request |
| mem_ack | input | 1 | Response valid, one cycle per request |
| mem_rdata | input | ELEM_W | Response data |
| mem_fault | input | 1 | Response fault flag, valid with `mem_ack` |
| dest | output | LANES*ELEM_W | Destination vector, lane l at bits [l*ELEM_W +: ELEM_W] |
| ffr | output | LANES*ELEM_W/8 | First-fault predicate read port |
| ffr_first | output | 1 | Lowest predicate bit |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle end-of-load pulse |

## Verification
Two predicate updates can land on the same edge: the set command and the fault-driven clear. The bench provokes this by asserting `ffr_set` combinationally whenever it sees a faulting acknowledge, so both are sampled on the same edge. It starts from a predicate that is already mostly zero. The result is judged at the port: the bits below the faulting lane must have been raised, and the bits from the faulting lane upward must read zero. A lone set or a lone clear cannot give that pattern.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_WAIT = 2'd2
   } seq_state_t;
endpackage

// File: rtl/ffl_lane_seq.sv
module ffl_lane_seq #(
   parameter int LANES = 4,
   parameter int IDX_W = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LANES-1:0] act_mask,
   input  logic             mem_ack,
   input  logic             mem_fault,
   output logic             busy,
   output logic [IDX_W-1:0] lane,
   output logic             req,
   output logic             load_go,
   output logic             wr_en,
   output logic             fault_hit,
   output logic             done
);
   import ffl_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

   seq_state_t       state;
   logic [LANES-1:0] mask_q;
   logic             at_last;

   assign busy      = (state != ST_IDLE);
   assign req       = (state == ST_WAIT);
   assign load_go   = start && (state == ST_IDLE);
   assign wr_en     = (state == ST_WAIT) && mem_ack && !mem_fault;
   assign fault_hit = (state == ST_WAIT) && mem_ack && mem_fault;
   assign at_last   = (lane == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         lane   <= '0;
         mask_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  mask_q <= act_mask;
                  lane   <= '0;
                  state  <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (mask_q[lane]) begin
                  state <= ST_WAIT;
               end else if (at_last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  lane <= lane + 1'b1;
               end
            end
            ST_WAIT: begin
               if (mem_ack) begin
                  if (mem_fault || at_last) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else begin
                     lane  <= lane + 1'b1;
                     state <= ST_SCAN;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ffl_ffr_reg.sv
module ffl_ffr_reg #(
   parameter int LANES = 4,
   parameter int BPL   = 4,
   parameter int IDX_W = $clog2(LANES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   set_all,
   input  logic                   clr_en,
   input  logic [IDX_W-1:0]       clr_lane,
   output logic [LANES*BPL-1:0]   ffr_q
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic kill;
      assign kill = clr_en && (clr_lane <= IDX_W'(l));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ffr_q[l*BPL +: BPL] <= '1;
         end else if (kill) begin
            ffr_q[l*BPL +: BPL] <= '0;
         end else if (set_all) begin
            ffr_q[l*BPL +: BPL] <= '1;
         end
      end
   end
endmodule

// File: rtl/ffl_dest_asm.sv
module ffl_dest_asm #(
   parameter int LANES  = 4,
   parameter int ELEM_W = 32,
   parameter int IDX_W  = $clog2(LANES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_all,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_lane,
   input  logic [ELEM_W-1:0]       wr_data,
   output logic [LANES*ELEM_W-1:0] dest_q
);
   for (genvar l = 0; l < LANES; l++) begin : g_elem
      logic hit;
      assign hit = wr_en && (wr_lane == IDX_W'(l));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dest_q[l*ELEM_W +: ELEM_W] <= '0;
         end else if (clr_all) begin
            dest_q[l*ELEM_W +: ELEM_W] <= '0;
         end else if (hit) begin
            dest_q[l*ELEM_W +: ELEM_W] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/ffl_gather_tracker.sv
module ffl_gather_tracker #(
   parameter int LANES  = 4,
   parameter int ELEM_W = 32,
   parameter int ADDR_W = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [LANES-1:0]             act_mask,
   input  logic [LANES*ADDR_W-1:0]      addr_vec,
   input  logic                         ffr_set,
   output logic                         mem_req,
   output logic [ADDR_W-1:0]            mem_addr,
   input  logic                         mem_ack,
   input  logic [ELEM_W-1:0]            mem_rdata,
   input  logic                         mem_fault,
   output logic [LANES*ELEM_W-1:0]      dest,
   output logic [LANES*(ELEM_W/8)-1:0]  ffr,
   output logic                         ffr_first,
   output logic                         busy,
   output logic                         done
);
   localparam int BPL   = ELEM_W / 8;
   localparam int FFR_W = LANES * BPL;
   localparam int IDX_W = $clog2(LANES);

   if (LANES < 2) begin : g_bad_lanes
      $error("ffl_gather_tracker: LANES must be at least 2");
   end
   if ((ELEM_W % 8) != 0 || ELEM_W < 8) begin : g_bad_elem
      $error("ffl_gather_tracker: ELEM_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ffl_gather_tracker: ADDR_W must be positive");
   end

   logic [IDX_W-1:0]        lane;
   logic                    load_go;
   logic                    wr_en;
   logic                    fault_hit;
   logic [LANES*ADDR_W-1:0] addr_q;

   ffl_lane_seq #(.LANES(LANES), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .act_mask  (act_mask),
      .mem_ack   (mem_ack),
      .mem_fault (mem_fault),
      .busy      (busy),
      .lane      (lane),
      .req       (mem_req),
      .load_go   (load_go),
      .wr_en     (wr_en),
      .fault_hit (fault_hit),
      .done      (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load_go) begin
         addr_q <= addr_vec;
      end
   end

   assign mem_addr = addr_q[lane*ADDR_W +: ADDR_W];

   ffl_ffr_reg #(.LANES(LANES), .BPL(BPL), .IDX_W(IDX_W)) u_ffr (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_all  (ffr_set),
      .clr_en   (fault_hit),
      .clr_lane (lane),
      .ffr_q    (ffr)
   );

   ffl_dest_asm #(.LANES(LANES), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_dest (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (load_go),
      .wr_en   (wr_en),
      .wr_lane (lane),
      .wr_data (mem_rdata),
      .dest_q  (dest)
   );

   assign ffr_first = ffr[0];

   logic unused_ok;
   assign unused_ok = (FFR_W > 0);
endmodule

// File: rtl/ffl_gather_tracker_chk.sv
module ffl_gather_tracker_chk #(
   parameter int LANES  = 4,
   parameter int ELEM_W = 32,
   parameter int ADDR_W = 16
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ffr_set,
   input logic                        mem_req,
   input logic                        mem_ack,
   input logic                        mem_fault,
   input logic [ADDR_W-1:0]           mem_addr,
   input logic [LANES*(ELEM_W/8)-1:0] ffr,
   input logic                        busy,
   input logic                        done
);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R6
   stop_after_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_fault) |=> !mem_req);

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R2
   set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ffr_set && !(mem_req && mem_ack && mem_fault)) |=> (&ffr));

   // R11
   no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ffr_set |=> ((ffr & ~$past(ffr)) == '0));
endmodule

bind ffl_gather_tracker ffl_gather_tracker_chk #(
   .LANES(LANES), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ffr_set   (ffr_set),
   .mem_req   (mem_req),
   .mem_ack   (mem_ack),
   .mem_fault (mem_fault),
   .mem_addr  (mem_addr),
   .ffr       (ffr),
   .busy      (busy),
   .done      (done)
);

// File: tb/sim_ffl_gather_tracker.sv
module sim_ffl_gather_tracker;
   localparam int LANES  = 4;
   localparam int ELEM_W = 32;
   localparam int ADDR_W = 16;
   localparam int FFR_W  = LANES * ELEM_W / 8;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      start = 1'b0;
   logic [LANES-1:0]          act_mask = '0;
   logic [LANES*ADDR_W-1:0]   addr_vec = '0;
   logic                      set_man = 1'b0;
   logic                      set_on_fault = 1'b0;
   logic                      ffr_set;
   logic                      mem_req;
   logic [ADDR_W-1:0]         mem_addr;
   logic                      mem_ack = 1'b0;
   logic [ELEM_W-1:0]         mem_rdata = '0;
   logic                      mem_fault = 1'b0;
   logic [LANES*ELEM_W-1:0]   dest;
   logic [FFR_W-1:0]          ffr;
   logic                      ffr_first;
   logic                      busy;
   logic                      done;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wait_cnt = 0;
   int ack_cnt = 0;
   int done_cnt = 0;
   int order_err = 0;
   int last_lane = -1;
   int cycles = 0;

   always #4 clk = ~clk;

   assign ffr_set = set_man | (set_on_fault & mem_ack & mem_fault);

   ffl_gather_tracker #(.LANES(LANES), .ELEM_W(ELEM_W), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .act_mask(act_mask),
      .addr_vec(addr_vec), .ffr_set(ffr_set), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mem_fault(mem_fault), .dest(dest), .ffr(ffr), .ffr_first(ffr_first),
      .busy(busy), .done(done)
   );

   function automatic logic [ELEM_W-1:0] mem_data(input logic [ADDR_W-1:0] a);
      return {a ^ 16'hC3C3, a};
   endfunction

   function automatic logic is_bad(input logic [ADDR_W-1:0] a);
      return a[15:12] == 4'hF;
   endfunction

   // memory model: response after lat+1 cycles
   always @(posedge clk) begin
      if (mem_ack) begin
         mem_ack   <= 1'b0;
         mem_fault <= 1'b0;
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem_data(mem_addr);
            mem_fault <= is_bad(mem_addr);
            wait_cnt  <= 0;
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (mem_ack) begin
         ack_cnt <= ack_cnt + 1;
         if (int'(mem_addr[7:4]) <= last_lane) order_err <= order_err + 1;
         last_lane <= int'(mem_addr[7:4]);
      end
      if (done) done_cnt <= done_cnt + 1;
   end

   initial begin
      forever begin
         @(negedge clk);
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [LANES*ADDR_W-1:0] mk_addrs(input int tag, input int flt);
      logic [LANES*ADDR_W-1:0] v;
      for (int l = 0; l < LANES; l++)
         v[l*ADDR_W +: ADDR_W] = {(l == flt) ? 4'hF : 4'h1, 4'(tag), 4'(l), 4'h3};
      return v;
   endfunction

   function automatic logic [LANES*ELEM_W-1:0] model_dest(input logic [LANES-1:0] m,
                                                          input logic [LANES*ADDR_W-1:0] av);
      logic [LANES*ELEM_W-1:0] d = '0;
      logic stop = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         if (!stop && m[l]) begin
            if (is_bad(av[l*ADDR_W +: ADDR_W])) stop = 1'b1;
            else d[l*ELEM_W +: ELEM_W] = mem_data(av[l*ADDR_W +: ADDR_W]);
         end
      end
      return d;
   endfunction

   // runs one load; returns after done, sampling at negedges
   task automatic run_load(input logic [LANES-1:0] m, input int tag, input int flt,
                           input int l_lat, input logic pre_set, input logic dbl_start);
      int t = 0;
      lat = l_lat;
      ack_cnt = 0; done_cnt = 0; order_err = 0; last_lane = -1;
      if (pre_set) begin
         @(negedge clk); set_man = 1'b1;
         @(negedge clk); set_man = 1'b0;
      end
      @(negedge clk);
      act_mask = m; addr_vec = mk_addrs(tag, flt); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (dbl_start) begin
         act_mask = '1; addr_vec = mk_addrs(tag + 1, 9); start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && t < 400) begin
         @(negedge clk);
         t++;
      end
   endtask

   localparam logic [3:0]  V_MASK [6] = '{4'hF, 4'hF, 4'h5, 4'hF, 4'h0, 4'hE};
   localparam int          V_FLT  [6] = '{9, 2, 1, 0, 9, 3};
   localparam int          V_LAT  [6] = '{0, 1, 2, 3, 0, 1};
   localparam logic [15:0] V_FFR  [6] = '{16'hFFFF, 16'h00FF, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0FFF};
   localparam int          V_REQ  [6] = '{4, 3, 2, 1, 0, 3};

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 ffr", 128'(ffr), 128'hFFFF);
      chk("R1 dest", 128'(dest), 128'h0);
      chk("R1 req/done/busy", 128'({mem_req, done, busy}), 128'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int e = 0; e < 6; e++) begin
         logic [LANES*ELEM_W-1:0] exp_d;
         run_load(V_MASK[e], e, V_FLT[e], V_LAT[e], 1'b1, 1'b0);
         exp_d = model_dest(V_MASK[e], mk_addrs(e, V_FLT[e]));
         chk("R7 done seen", 128'(done), 128'h1);
         chk("R7 busy low at done", 128'(busy), 128'h0);
         chk("R4 R5 R6 dest", 128'(dest), 128'(exp_d));
         chk("R6 R5 R4 ffr", 128'(ffr), 128'(V_FFR[e]));
         chk("R8 ffr_first", 128'(ffr_first), 128'(V_FFR[e][0]));
         @(negedge clk);
         chk("R7 done one cycle", 128'(done), 128'h0);
         repeat (lat + 4) @(negedge clk);
         chk("R3 R5 R6 request count", 128'(ack_cnt), 128'(V_REQ[e]));
         chk("R3 ascending order", 128'(order_err), 128'h0);
         chk("R7 one done per load", 128'(done_cnt), 128'h1);
      end

      // R11: fault in lane 1, then a clean load must not raise bits
      run_load(4'hF, 7, 1, 1, 1'b1, 1'b0);
      chk("R6 ffr lane1 fault", 128'(ffr), 128'h000F);
      run_load(4'hF, 8, 9, 0, 1'b0, 1'b0);
      chk("R11 ffr unchanged by clean load", 128'(ffr), 128'h000F);
      chk("R4 dest clean load", 128'(dest), 128'(model_dest(4'hF, mk_addrs(8, 9))));

      // R9: set command in the same cycle as fault clear in lane 2
      set_on_fault = 1'b1;
      run_load(4'hF, 10, 2, 2, 1'b0, 1'b0);
      set_on_fault = 1'b0;
      chk("R9 set with clear", 128'(ffr), 128'h00FF);
      chk("R8 ffr_first after R9", 128'(ffr_first), 128'h1);

      // R2: idle set restores all ones
      @(negedge clk); set_man = 1'b1;
      @(negedge clk); set_man = 1'b0;
      chk("R2 idle set", 128'(ffr), 128'hFFFF);

      // R10: second start while busy is ignored
      run_load(4'h1, 11, 9, 3, 1'b0, 1'b1);
      repeat (10) @(negedge clk);
      chk("R10 request count", 128'(ack_cnt), 128'h1);
      chk("R10 dest", 128'(dest), 128'(model_dest(4'h1, mk_addrs(11, 9))));
      chk("R10 idle afterwards", 128'({busy, mem_req}), 128'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule